// File: doc/BRIEF.md
# Debug System Bus Master

This block lets a debugger reach target memory without involving a processor. The debugger sees three 32-bit registers on a plain register port: a control word, an address register and a data register. Accesses to the address and data registers have side effects. They start single read or write transactions on a memory-side bus, and the block reports any failure through sticky error fields that software clears by writing ones.

The memory side uses two valid/ready channels. The request channel holds its valid signal and all payload stable until ready is seen, so the memory may stall for any number of cycles. The response channel raises ready only while a transaction is waiting for its answer, and one response retires the single outstanding request. Only one transaction is ever in flight. The register port has no back-pressure: read data is combinational from the current register state, and side effects take place at the clock edge of the access.

Top module: `sbx_unit`

## Requirements
- R1: The register port decodes address 0 as control word, 1 as address, 2 as data (3 reads zero). The control word bits are: size [2:0] (reset 2), auto-increment [3], read-on-address [4], read-on-data [5], error code [8:6], busy-error [9], busy [10] read-only, size capability bits [13:11] read-only 1 (8/16/32-bit), version [31:29] read-only 1. The reset value is 0x20003802 and the address and data registers reset to 0.
- R2: Size codes 0, 1 and 2 move 1, 2 and 4 bytes. The write strobe has bit n set for byte lane n = address[1:0] up to address[1:0]+2^size-1, and the write data is shifted left by 8*address[1:0].
- R3: Writing the data register while idle stores the value and starts a bus write to the current address.
- R4: With read-on-address set, writing the address register while idle stores it and starts a bus read at the new address.
- R5: With read-on-data set, reading the data register while idle returns its current value and then starts a bus read at the current address.
- R6: With auto-increment set, the address advances by 2^size after each access that completes without error; an access that ends in error leaves it unchanged.
- R7: A bus error response sets the error code to 2, for reads and writes.
- R8: A trigger with size code above 2 sets error code 4. A trigger whose address is not a multiple of 2^size sets error code 3. Neither issues a bus request.
- R9: Writing the control word clears each error-code bit written as 1 and leaves the others.
- R10: Writing the address or data register, or reading the data register, while busy sets the sticky busy-error flag and is otherwise ignored. Writing 1 to bit 9 clears the flag.
- R11: No bus access starts while the error code is nonzero or busy-error is set.
- R12: Busy is high from the edge of the triggering access until the response handshake. The request payload stays stable while valid waits for ready.
- R13: Sub-word read data lands right-aligned in the data register, zero-extended, taken from the lanes selected by the low address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_req_valid | output | 1 | Request valid |
| bus_req_ready | input | 1 | Request accepted by memory |
| bus_req_we | output | 1 | Request is a write |
| bus_req_addr | output | ADDR_W | Byte address |
| bus_req_wdata | output | 32 | Lane-placed write data |
| bus_req_strb | output | 4 | Byte-lane enables |
| bus_rsp_valid | input | 1 | Response valid |
| bus_rsp_ready | output | 1 | Block waits for a response |
| bus_rsp_rdata | input | 32 | Full-word read data |
| bus_rsp_err | input | 1 | Response reports an error |

## Verification
A triggering register access takes effect at its own clock edge, so the busy bit, any size or alignment error code and the busy-error flag can be seen on the next control-word read. Stored register values also appear one edge after the write. The data and address results of a bus access only appear after the response handshake, and the memory model in the bench delays that by a variable number of cycles. For this reason the bench polls the busy bit until it falls before it reads back data, address or error code. Read data is sampled one time unit after the falling edge, before the edge that would apply a read-on-data side effect.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
  localparam int DW = 32;
  localparam int NLANE = DW / 8;

  localparam logic [1:0] RG_CTRL = 2'd0;
  localparam logic [1:0] RG_ADDR = 2'd1;
  localparam logic [1:0] RG_DATA = 2'd2;

  localparam int B_INC   = 3;
  localparam int B_RDA   = 4;
  localparam int B_RDD   = 5;
  localparam int B_ERR   = 6;
  localparam int B_BZERR = 9;

  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_BUS   = 3'd2;
  localparam logic [2:0] ERR_ALIGN = 3'd3;
  localparam logic [2:0] ERR_SIZE  = 3'd4;

  localparam logic [2:0] SIZE_MAX = 3'd2;
  localparam logic [2:0] VERSION  = 3'd1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } eng_state_e;
endpackage

// File: rtl/sbx_lane.sv
module sbx_lane
  import sbx_pkg::*;
(
  input  logic [2:0]      size,
  input  logic [1:0]      off,
  input  logic [DW-1:0]   wdata,
  output logic            size_ok,
  output logic            misalign,
  output logic [NLANE-1:0] strb,
  output logic [DW-1:0]   lane_wdata
);
  logic [2:0] nbytes;
  logic [2:0] off_w;

  assign size_ok  = (size <= SIZE_MAX);
  assign nbytes   = 3'd1 << size[1:0];
  assign off_w    = {1'b0, off};
  assign misalign = ((size == 3'd1) && off[0]) ||
                    ((size == 3'd2) && (off != 2'd0));

  for (genvar b = 0; b < NLANE; b++) begin : g_lane
    localparam logic [2:0] LB = 3'(b);
    assign strb[b] = size_ok && (LB >= off_w) && (LB < off_w + nbytes);
  end

  assign lane_wdata = wdata << {off, 3'b000};
endmodule

// File: rtl/sbx_engine.sv
module sbx_engine
  import sbx_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_we,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [1:0]        start_size,
  input  logic [DW-1:0]     start_wdata,
  input  logic [NLANE-1:0]  start_strb,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_we,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DW-1:0]     bus_req_wdata,
  output logic [NLANE-1:0]  bus_req_strb,
  input  logic              bus_rsp_valid,
  output logic              bus_rsp_ready,
  input  logic [DW-1:0]     bus_rsp_rdata,
  input  logic              bus_rsp_err,
  output logic              busy,
  output logic              done,
  output logic              done_err,
  output logic              done_we,
  output logic [1:0]        done_size,
  output logic [DW-1:0]     done_rdata
);
  eng_state_e        st_q;
  logic [ADDR_W-1:0] a_q;
  logic              we_q;
  logic [DW-1:0]     wd_q;
  logic [NLANE-1:0]  sb_q;
  logic [1:0]        sz_q;
  logic [DW-1:0]     shifted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      a_q  <= '0;
      we_q <= 1'b0;
      wd_q <= '0;
      sb_q <= '0;
      sz_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q <= ST_REQ;
          a_q  <= start_addr;
          we_q <= start_we;
          wd_q <= start_wdata;
          sb_q <= start_we ? start_strb : '0;
          sz_q <= start_size;
        end
        ST_REQ:  if (bus_req_ready) st_q <= ST_RSP;
        ST_RSP:  if (bus_rsp_valid) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req_valid = (st_q == ST_REQ);
  assign bus_req_we    = we_q;
  assign bus_req_addr  = a_q;
  assign bus_req_wdata = wd_q;
  assign bus_req_strb  = sb_q;
  assign bus_rsp_ready = (st_q == ST_RSP);
  assign busy          = (st_q != ST_IDLE);
  assign done          = (st_q == ST_RSP) && bus_rsp_valid;
  assign done_err      = bus_rsp_err;
  assign done_we       = we_q;
  assign done_size     = sz_q;

  assign shifted = bus_rsp_rdata >> {a_q[1:0], 3'b000};
  always_comb begin
    unique case (sz_q)
      2'd0:    done_rdata = {{(DW-8){1'b0}}, shifted[7:0]};
      2'd1:    done_rdata = {{(DW-16){1'b0}}, shifted[15:0]};
      default: done_rdata = shifted;
    endcase
  end

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=>
      bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_strb) && $stable(bus_req_wdata))
    else $error("request dropped or changed before ready");

  p_strb_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_req_we |-> $countones(bus_req_strb) == (32'd1 << sz_q))
    else $error("strobe count does not match size");
endmodule

// File: rtl/sbx_unit.sv
module sbx_unit
  import sbx_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_we,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [31:0]       bus_req_wdata,
  output logic [3:0]        bus_req_strb,
  input  logic              bus_rsp_valid,
  output logic              bus_rsp_ready,
  input  logic [31:0]       bus_rsp_rdata,
  input  logic              bus_rsp_err
);
  logic [2:0]        size_q;
  logic              inc_q, rda_q, rdd_q;
  logic [2:0]        err_q, err_d;
  logic              bz_q, bz_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     data_q;

  logic wr_ctrl, wr_adr, wr_dat, rd_dat;
  logic eng_busy, eng_done, eng_err, eng_we;
  logic [1:0]    eng_size;
  logic [DW-1:0] eng_rdata;
  logic busy_hit, want_rd, want_wr, want, clean, go;
  logic size_ok, misalign;
  logic [ADDR_W-1:0] tgt_addr;
  logic [DW-1:0]     tgt_data, lane_wdata;
  logic [NLANE-1:0]  lane_strb;

  assign wr_ctrl = reg_en && reg_we  && (reg_addr == RG_CTRL);
  assign wr_adr  = reg_en && reg_we  && (reg_addr == RG_ADDR);
  assign wr_dat  = reg_en && reg_we  && (reg_addr == RG_DATA);
  assign rd_dat  = reg_en && !reg_we && (reg_addr == RG_DATA);

  assign busy_hit = eng_busy && (wr_adr || wr_dat || rd_dat);
  assign want_rd  = !eng_busy && ((wr_adr && rda_q) || (rd_dat && rdd_q));
  assign want_wr  = !eng_busy && wr_dat;
  assign want     = want_rd || want_wr;
  assign clean    = (err_q == ERR_NONE) && !bz_q;

  assign tgt_addr = wr_adr ? reg_wdata[ADDR_W-1:0] : addr_q;
  assign tgt_data = wr_dat ? reg_wdata : data_q;

  sbx_lane u_lane (
    .size       (size_q),
    .off        (tgt_addr[1:0]),
    .wdata      (tgt_data),
    .size_ok    (size_ok),
    .misalign   (misalign),
    .strb       (lane_strb),
    .lane_wdata (lane_wdata)
  );

  assign go = want && clean && size_ok && !misalign;

  sbx_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (go),
    .start_we      (want_wr),
    .start_addr    (tgt_addr),
    .start_size    (size_q[1:0]),
    .start_wdata   (lane_wdata),
    .start_strb    (lane_strb),
    .bus_req_valid (bus_req_valid),
    .bus_req_ready (bus_req_ready),
    .bus_req_we    (bus_req_we),
    .bus_req_addr  (bus_req_addr),
    .bus_req_wdata (bus_req_wdata),
    .bus_req_strb  (bus_req_strb),
    .bus_rsp_valid (bus_rsp_valid),
    .bus_rsp_ready (bus_rsp_ready),
    .bus_rsp_rdata (bus_rsp_rdata),
    .bus_rsp_err   (bus_rsp_err),
    .busy          (eng_busy),
    .done          (eng_done),
    .done_err      (eng_err),
    .done_we       (eng_we),
    .done_size     (eng_size),
    .done_rdata    (eng_rdata)
  );

  // Error bookkeeping: clears first, then new events win.
  always_comb begin
    err_d = err_q;
    bz_d  = bz_q;
    if (wr_ctrl) begin
      err_d = err_q & ~reg_wdata[B_ERR +: 3];
      bz_d  = bz_q  & ~reg_wdata[B_BZERR];
    end
    if (busy_hit) bz_d = 1'b1;
    if (want && clean && !size_ok)      err_d = ERR_SIZE;
    else if (want && clean && misalign) err_d = ERR_ALIGN;
    if (eng_done && eng_err) err_d = ERR_BUS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= SIZE_MAX;
      inc_q  <= 1'b0;
      rda_q  <= 1'b0;
      rdd_q  <= 1'b0;
      err_q  <= ERR_NONE;
      bz_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      err_q <= err_d;
      bz_q  <= bz_d;
      if (wr_ctrl) begin
        size_q <= reg_wdata[2:0];
        inc_q  <= reg_wdata[B_INC];
        rda_q  <= reg_wdata[B_RDA];
        rdd_q  <= reg_wdata[B_RDD];
      end
      if (wr_adr && !eng_busy)
        addr_q <= reg_wdata[ADDR_W-1:0];
      else if (eng_done && !eng_err && inc_q)
        addr_q <= addr_q + (ADDR_W'(1) << eng_size);
      if (wr_dat && !eng_busy)
        data_q <= reg_wdata;
      else if (eng_done && !eng_err && !eng_we)
        data_q <= eng_rdata;
    end
  end

  always_comb begin
    unique case (reg_addr)
      RG_CTRL: reg_rdata = {VERSION, 15'd0, 3'b111, eng_busy, bz_q, err_q,
                            rdd_q, rda_q, inc_q, size_q};
      RG_ADDR: reg_rdata = 32'(addr_q);
      RG_DATA: reg_rdata = data_q;
      default: reg_rdata = '0;
    endcase
  end

  p_start_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_valid) |-> ($past(err_q) == ERR_NONE) && !$past(bz_q))
    else $error("access started with an error pending");

  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && (reg_wdata[B_ERR +: 3] == 3'b111) && !eng_done |=> err_q == ERR_NONE)
    else $error("error code not cleared");

  p_noinc_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done && eng_err |=> $stable(addr_q))
    else $error("address moved after failed access");

  p_bus_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done && eng_err |=> err_q == ERR_BUS)
    else $error("bus error not recorded");

  p_busy_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_hit |=> bz_q)
    else $error("busy-error not set");
endmodule

// File: tb/sbx_unit_tb_top.sv
module sbx_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        bus_req_valid, bus_req_we, bus_rsp_ready;
  logic        bus_req_ready;
  logic [31:0] bus_req_addr, bus_req_wdata;
  logic [3:0]  bus_req_strb;
  logic        bus_rsp_valid, bus_rsp_err;
  logic [31:0] bus_rsp_rdata;

  always #4 clk = ~clk;

  sbx_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_we(bus_req_we), .bus_req_addr(bus_req_addr),
    .bus_req_wdata(bus_req_wdata), .bus_req_strb(bus_req_strb),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_ready(bus_rsp_ready),
    .bus_rsp_rdata(bus_rsp_rdata), .bus_rsp_err(bus_rsp_err)
  );

  // Memory model: alternating ready, fixed response delay, bit 31 = bad address.
  logic [31:0] mem [0:63];
  int          txn_cnt;
  logic [3:0]  last_strb;
  int          dly;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_req_ready <= 1'b0;
      bus_rsp_valid <= 1'b0;
      bus_rsp_err   <= 1'b0;
      bus_rsp_rdata <= 32'd0;
      txn_cnt <= 0;
      last_strb <= 4'd0;
      dly <= 0;
      for (int i = 0; i < 64; i++) mem[i] <= 32'd0;
    end else begin
      bus_req_ready <= ~bus_req_ready;
      if (bus_req_valid && bus_req_ready) begin
        txn_cnt   <= txn_cnt + 1;
        last_strb <= bus_req_strb;
        bus_rsp_err   <= bus_req_addr[31];
        bus_rsp_rdata <= mem[bus_req_addr[7:2]];
        dly <= 3;
        if (bus_req_we && !bus_req_addr[31])
          for (int b = 0; b < 4; b++)
            if (bus_req_strb[b]) mem[bus_req_addr[7:2]][8*b +: 8] <= bus_req_wdata[8*b +: 8];
      end else if (dly > 1) dly <= dly - 1;
      else if (dly == 1) begin
        dly <= 0;
        bus_rsp_valid <= 1'b1;
      end
      if (bus_rsp_valid && bus_rsp_ready) bus_rsp_valid <= 1'b0;
    end
  end

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_en = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int i = 0; i < 60; i++) begin
      reg_rd(2'd0, c);
      if (!c[10]) return;
    end
  endtask

  typedef struct packed {
    logic [2:0]  size;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  strb;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{3'd2, 32'h40, 32'hDEADBEEF, 32'hDEADBEEF, 4'b1111},
    '{3'd1, 32'h46, 32'h1234ABCD, 32'h0000ABCD, 4'b1100},
    '{3'd0, 32'h4B, 32'h87654321, 32'h00000021, 4'b1000},
    '{3'd0, 32'h48, 32'hFFFFFF5A, 32'h0000005A, 4'b0001},
    '{3'd1, 32'h44, 32'h0000C0DE, 32'h0000C0DE, 4'b0011},
    '{3'd2, 32'h7C, 32'h08675309, 32'h08675309, 4'b1111}
  };

  initial begin
    logic [31:0] v;
    int snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd(2'd0, v); check("R1 ctrl reset", v, 32'h20003802);
    reg_rd(2'd1, v); check("R1 addr reset", v, 32'd0);
    reg_rd(2'd2, v); check("R1 data reset", v, 32'd0);
    reg_rd(2'd3, v); check("R1 unused reads zero", v, 32'd0);

    // Table: write each vector, then read it back with read-on-address
    foreach (VEC[k]) begin
      reg_wr(2'd0, {29'd0, VEC[k].size});
      reg_wr(2'd1, VEC[k].addr);
      reg_wr(2'd2, VEC[k].wdata);
      reg_rd(2'd0, v); check("R12 busy after trigger", {31'd0, v[10]}, 32'd1);
      wait_idle();
      check("R2 write strobe", {28'd0, last_strb}, {28'd0, VEC[k].strb});
      reg_wr(2'd0, {27'd0, 1'b1, 1'b0, VEC[k].size});
      reg_wr(2'd1, VEC[k].addr);
      wait_idle();
      reg_rd(2'd2, v); check("R3 R4 R13 readback", v, VEC[k].exp);
    end
    check("R3 R4 transaction count", 32'(txn_cnt), 32'd12);

    // R2 lane placement seen as full words
    reg_wr(2'd0, 32'h12);
    reg_wr(2'd1, 32'h44); wait_idle();
    reg_rd(2'd2, v); check("R2 merged word 0x44", v, 32'hABCDC0DE);
    reg_wr(2'd1, 32'h48); wait_idle();
    reg_rd(2'd2, v); check("R2 merged word 0x48", v, 32'h2100005A);

    // R6 auto-increment on writes
    reg_wr(2'd0, 32'h0A);
    reg_wr(2'd1, 32'h60);
    for (int i = 0; i < 3; i++) begin reg_wr(2'd2, 32'(i)); wait_idle(); end
    reg_rd(2'd1, v); check("R6 word increment", v, 32'h6C);
    reg_wr(2'd0, 32'h09);
    reg_wr(2'd1, 32'h50);
    reg_wr(2'd2, 32'h77); wait_idle();
    reg_rd(2'd1, v); check("R6 halfword increment", v, 32'h52);

    // R5 read-on-data streaming
    reg_wr(2'd0, 32'h2A);
    reg_wr(2'd1, 32'h60);
    reg_rd(2'd2, v); check("R5 returns current value", v, 32'h77);
    wait_idle();
    for (int i = 0; i < 3; i++) begin
      reg_rd(2'd2, v); check("R5 streamed value", v, 32'(i));
      wait_idle();
    end
    reg_rd(2'd1, v); check("R5 R6 final address", v, 32'h70);

    // R7 bus error on read, R6 no increment, R11 blocked, R9 clear
    reg_wr(2'd0, 32'h1A);
    reg_wr(2'd1, 32'h80000000); wait_idle();
    reg_rd(2'd0, v); check("R7 read error code", {29'd0, v[8:6]}, 32'd2);
    reg_rd(2'd1, v); check("R6 no increment on error", v, 32'h80000000);
    snap = txn_cnt;
    reg_wr(2'd2, 32'h5); repeat (6) @(negedge clk);
    check("R11 no start while error", 32'(txn_cnt), 32'(snap));
    reg_wr(2'd0, 32'h1A | (32'd2 << 6));
    reg_rd(2'd0, v); check("R9 clear bus error", {29'd0, v[8:6]}, 32'd0);

    // R7 bus error on write
    reg_wr(2'd0, 32'h02);
    reg_wr(2'd1, 32'h80000004);
    reg_wr(2'd2, 32'h1); wait_idle();
    reg_rd(2'd0, v); check("R7 write error code", {29'd0, v[8:6]}, 32'd2);
    reg_wr(2'd0, 32'h02 | (32'd2 << 6));

    // R8 unsupported size
    reg_wr(2'd0, 32'h04);
    reg_wr(2'd1, 32'h40);
    snap = txn_cnt;
    reg_wr(2'd2, 32'hFEEDBABE); repeat (6) @(negedge clk);
    reg_rd(2'd0, v); check("R8 size error code", {29'd0, v[8:6]}, 32'd4);
    check("R8 no request on bad size", 32'(txn_cnt), 32'(snap));
    reg_wr(2'd0, 32'h04 | (32'd4 << 6));

    // R8 misaligned, R9 per-bit clear
    reg_wr(2'd0, 32'h01);
    reg_wr(2'd1, 32'h41);
    snap = txn_cnt;
    reg_wr(2'd2, 32'h1111); repeat (6) @(negedge clk);
    reg_rd(2'd0, v); check("R8 align error code", {29'd0, v[8:6]}, 32'd3);
    check("R8 no request on misalign", 32'(txn_cnt), 32'(snap));
    reg_wr(2'd0, 32'h01 | (32'd1 << 6));
    reg_rd(2'd0, v); check("R9 partial clear", {29'd0, v[8:6]}, 32'd2);
    reg_wr(2'd0, 32'h01 | (32'd2 << 6));
    reg_rd(2'd0, v); check("R9 full clear", {29'd0, v[8:6]}, 32'd0);

    // R10 busy-error
    reg_wr(2'd0, 32'h02);
    reg_wr(2'd1, 32'h40);
    reg_wr(2'd2, 32'h0BADF00D);
    reg_wr(2'd1, 32'h999);
    wait_idle();
    reg_rd(2'd0, v); check("R10 busy-error set", {31'd0, v[9]}, 32'd1);
    reg_rd(2'd1, v); check("R10 address write ignored", v, 32'h40);
    snap = txn_cnt;
    reg_wr(2'd2, 32'h3); repeat (6) @(negedge clk);
    check("R11 no start while busy-error", 32'(txn_cnt), 32'(snap));
    reg_wr(2'd0, 32'h202);
    reg_rd(2'd0, v); check("R10 busy-error cleared", {31'd0, v[9]}, 32'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule